// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative store of recent virtual-page to physical-frame translations. Every entry carries an address-space tag, a page size (4 KB, 2 MB or 1 GB), a global flag and four permission bits. A lookup presents a virtual address, the current address-space identifier, the access kind and the privilege level. In the same cycle the block answers with one of three outcomes: a translated physical address, a miss, or a permission fault.

A page-table walker answers misses through the fill port. A fill goes to a free entry when one exists. When every entry is in use, it replaces the least recently used entry. Software-driven maintenance uses two further inputs. One removes the translation covering a single virtual page. The other empties the whole array. Because entries are tagged, a process switch only changes the identifier presented on lookup, and no flush is needed.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss.
- R2: A lookup hits when a valid entry's page tag equals the address's page bits and the entry's identifier equals `lk_asid_i`. For a 4 KB entry, `lk_paddr_o` is the cached frame number joined with the untranslated low 12 address bits.
- R3: A lookup whose identifier differs from a non-global entry's misses. An entry filled with `fill_global_i`=1 matches under any identifier.
- R4: Size encoding is 0=4 KB, 1=2 MB, 2 or 3=1 GB. A 2 MB entry ignores page bits [8:0] in its compare and passes them through to frame bits [8:0]. A 1 GB entry does the same with page bits [17:0]. Page bits above the ignored range must still match.
- R5: Permission bits are [0]=read, [1]=write, [2]=execute, [3]=user. Access kind is 0=load, 1=store, 2=fetch, 3=load. A matching entry faults when a load lacks read, a store lacks write, a fetch lacks execute, or `lk_user_i`=1 and the user bit is clear. On a fault `lk_hit_o`=0 and `lk_paddr_o`=0.
- R6: While `lk_valid_i`=1, exactly one of hit, miss and fault is high. While it is 0, all three and `lk_paddr_o` are 0.
- R7: A fill lands on a free entry whenever one exists, so no valid translation is lost until all DEPTH entries are in use.
- R8: With all entries valid, a fill replaces the least recently used entry. An entry counts as used when it is filled, and on every clock edge where a lookup matches it (hit or fault).
- R9: A single-page invalidate removes every entry whose page, taken at that entry's own size, contains `inv_vpn_i`. This applies whatever the entry's identifier or global flag. Other entries are kept.
- R10: A full flush empties every entry. It overrides a fill presented in the same cycle.
- R11: Lookup is combinational. Fills and invalidates change lookup results only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | VA_W | Virtual address to translate |
| lk_asid_i | input | ASID_W | Current address-space identifier |
| lk_acc_i | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 load) |
| lk_user_i | input | 1 | Access is made at user privilege |
| lk_hit_o | output | 1 | Translation valid and permitted |
| lk_miss_o | output | 1 | No matching entry |
| lk_fault_o | output | 1 | Matching entry, permission violated |
| lk_paddr_o | output | PA_W | Physical address on a hit, else 0 |
| fill_valid_i | input | 1 | Write a new translation |
| fill_vpn_i | input | VA_W-12 | Virtual page number of the fill |
| fill_ppn_i | input | PA_W-12 | Physical frame number of the fill |
| fill_asid_i | input | ASID_W | Identifier of the fill |
| fill_size_i | input | 2 | Page size of the fill |
| fill_global_i | input | 1 | Fill matches any identifier |
| fill_perm_i | input | 4 | Permission bits {user, exec, write, read} |
| inv_page_i | input | 1 | Invalidate one virtual page |
| inv_vpn_i | input | VA_W-12 | Page number to invalidate |
| flush_all_i | input | 1 | Invalidate every entry |

## Verification
The hardest condition to reach from the ports is a replacement decision with every entry occupied and a known usage order. Lookups also update that order, so the order depends on which cycles a lookup was held across a clock edge. The stimulus first empties the array with a flush. It then fills exactly DEPTH distinct pages and reads each back once in a fixed sequence, so each read edge records one use. It re-reads the first page to make it the newest, which leaves the second page as the oldest. A final fill must then evict that page and no other. A second awkward case is same-cycle behaviour: a fill, an invalidate and a flush are each presented while a lookup of the affected page is held. The result is sampled both before and after the edge.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_1G = 2'd2} pg_size_e;
  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_e;

  localparam int unsigned OFS_W   = 12;
  localparam int unsigned SUPER_W = 18;

  // page-number bits ignored by an entry of the given size
  function automatic logic [SUPER_W-1:0] size_mask(logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = '0;
      2'd1:    size_mask = 18'h001FF;
      default: size_mask = 18'h3FFFF;
    endcase
  endfunction
endpackage

// File: rtl/tlb_slot.sv
`timescale 1ns/1ps
module tlb_slot #(
  parameter int unsigned VPN_W  = 36,
  parameter int unsigned PPN_W  = 28,
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              we_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [1:0]        wr_size_i,
  input  logic              wr_glob_i,
  input  logic [3:0]        wr_perm_i,
  input  logic              inv_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              valid_o,
  output logic              match_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic [3:0]        perm_o
);
  import tlb_pkg::*;
  localparam int unsigned HI_V = VPN_W - SUPER_W;

  logic              valid_q, glob_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [ASID_W-1:0] asid_q;
  logic [1:0]        size_q;
  logic [3:0]        perm_q;

  logic [SUPER_W-1:0] ign;
  logic               lk_tag_eq, inv_tag_eq, inv_hit;

  assign ign        = size_mask(size_q);
  assign lk_tag_eq  = (lk_vpn_i[VPN_W-1:SUPER_W] == vpn_q[VPN_W-1:SUPER_W]) &&
                      (((lk_vpn_i[SUPER_W-1:0] ^ vpn_q[SUPER_W-1:0]) & ~ign) == '0);
  assign inv_tag_eq = (inv_vpn_i[VPN_W-1:SUPER_W] == vpn_q[VPN_W-1:SUPER_W]) &&
                      (((inv_vpn_i[SUPER_W-1:0] ^ vpn_q[SUPER_W-1:0]) & ~ign) == '0);
  assign inv_hit    = valid_q & inv_tag_eq;

  assign valid_o = valid_q;
  assign match_o = valid_q & lk_tag_eq & (glob_q | (asid_q == lk_asid_i));
  assign ppn_o   = {ppn_q[PPN_W-1:SUPER_W],
                    (ppn_q[SUPER_W-1:0] & ~ign) | (lk_vpn_i[SUPER_W-1:0] & ign)};
  assign perm_o  = perm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      glob_q  <= 1'b0;
      vpn_q   <= '0;
      ppn_q   <= '0;
      asid_q  <= '0;
      size_q  <= 2'd0;
      perm_q  <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (we_i) begin
      valid_q <= 1'b1;
      glob_q  <= wr_glob_i;
      vpn_q   <= wr_vpn_i;
      ppn_q   <= wr_ppn_i;
      asid_q  <= wr_asid_i;
      size_q  <= wr_size_i;
      perm_q  <= wr_perm_i;
    end else if (inv_i && inv_hit) begin
      valid_q <= 1'b0;
    end
  end

  assert_fill_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !flush_i |=> valid_q);

  assert_inv_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i && inv_hit && !we_i && !flush_i |=> !valid_q);

  if (HI_V == 0) begin : g_chk_w
    initial assert (VPN_W > SUPER_W) else $error("VPN_W too small");
  end
endmodule

// File: rtl/tlb_lru.sv
`timescale 1ns/1ps
module tlb_lru #(
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [DEPTH-1:0] touch_oh_i,
  input  logic [DEPTH-1:0] valid_i,
  output logic [DEPTH-1:0] victim_oh_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] OLDEST = AW'(DEPTH - 1);

  // ages form a permutation of 0..DEPTH-1; 0 is newest
  logic [AW-1:0]    age_q [DEPTH];
  logic [AW-1:0]    touched_age;
  logic [DEPTH-1:0] free_oh, old_oh;
  logic             have_free;

  always_comb begin
    touched_age = '0;
    for (int i = 0; i < DEPTH; i++)
      if (touch_oh_i[i]) touched_age = touched_age | age_q[i];
  end

  always_comb begin
    free_oh   = '0;
    have_free = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      old_oh[i] = (age_q[i] == OLDEST);
      if (!valid_i[i] && !have_free) begin
        free_oh[i] = 1'b1;
        have_free  = 1'b1;
      end
    end
  end

  assign victim_oh_o = have_free ? free_oh : old_oh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= AW'(i);
    end else if (touch_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (touch_oh_i[i])                age_q[i] <= '0;
        else if (age_q[i] < touched_age)  age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  assert_lru_single_oldest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_i) |-> $onehot(old_oh));

  assert_victim_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&valid_i) |-> $onehot(victim_oh_o) && ((victim_oh_o & valid_i) == '0));
endmodule

// File: rtl/asid_tlb.sv
`timescale 1ns/1ps
module asid_tlb #(
  parameter int unsigned VA_W   = 48,
  parameter int unsigned PA_W   = 40,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lk_valid_i,
  input  logic [VA_W-1:0]          lk_vaddr_i,
  input  logic [ASID_W-1:0]        lk_asid_i,
  input  logic [1:0]               lk_acc_i,
  input  logic                     lk_user_i,
  output logic                     lk_hit_o,
  output logic                     lk_miss_o,
  output logic                     lk_fault_o,
  output logic [PA_W-1:0]          lk_paddr_o,
  input  logic                     fill_valid_i,
  input  logic [VA_W-13:0]         fill_vpn_i,
  input  logic [PA_W-13:0]         fill_ppn_i,
  input  logic [ASID_W-1:0]        fill_asid_i,
  input  logic [1:0]               fill_size_i,
  input  logic                     fill_global_i,
  input  logic [3:0]               fill_perm_i,
  input  logic                     inv_page_i,
  input  logic [VA_W-13:0]         inv_vpn_i,
  input  logic                     flush_all_i
);
  import tlb_pkg::*;
  localparam int unsigned VPN_W = VA_W - OFS_W;
  localparam int unsigned PPN_W = PA_W - OFS_W;

  logic [VPN_W-1:0] lk_vpn;
  logic [DEPTH-1:0] valid_vec, match_vec, victim_oh, fill_we, touch_oh;
  logic [PPN_W-1:0] slot_ppn  [DEPTH];
  logic [3:0]       slot_perm [DEPTH];
  logic [PPN_W-1:0] sel_ppn;
  logic [3:0]       sel_perm;
  logic             any_match, perm_bad, touch_en, fill_go;

  assign lk_vpn = lk_vaddr_i[VA_W-1:OFS_W];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    tlb_slot #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .flush_i  (flush_all_i),
      .we_i     (fill_we[g]),
      .wr_vpn_i (fill_vpn_i),
      .wr_ppn_i (fill_ppn_i),
      .wr_asid_i(fill_asid_i),
      .wr_size_i(fill_size_i),
      .wr_glob_i(fill_global_i),
      .wr_perm_i(fill_perm_i),
      .inv_i    (inv_page_i),
      .inv_vpn_i(inv_vpn_i),
      .lk_vpn_i (lk_vpn),
      .lk_asid_i(lk_asid_i),
      .valid_o  (valid_vec[g]),
      .match_o  (match_vec[g]),
      .ppn_o    (slot_ppn[g]),
      .perm_o   (slot_perm[g])
    );
  end

  // AND-OR select; fills never create overlapping entries
  always_comb begin
    sel_ppn  = '0;
    sel_perm = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_vec[i]) begin
        sel_ppn  = sel_ppn  | slot_ppn[i];
        sel_perm = sel_perm | slot_perm[i];
      end
    end
  end

  assign any_match = |match_vec;

  always_comb begin
    perm_bad = lk_user_i & ~sel_perm[3];
    case (lk_acc_i)
      ACC_STORE: perm_bad = perm_bad | ~sel_perm[1];
      ACC_FETCH: perm_bad = perm_bad | ~sel_perm[2];
      default:   perm_bad = perm_bad | ~sel_perm[0];
    endcase
  end

  assign lk_hit_o   = lk_valid_i & any_match & ~perm_bad;
  assign lk_fault_o = lk_valid_i & any_match &  perm_bad;
  assign lk_miss_o  = lk_valid_i & ~any_match;
  assign lk_paddr_o = lk_hit_o ? {sel_ppn, lk_vaddr_i[OFS_W-1:0]} : '0;

  tlb_lru #(.DEPTH(DEPTH)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (touch_en),
    .touch_oh_i (touch_oh),
    .valid_i    (valid_vec),
    .victim_oh_o(victim_oh)
  );

  assign fill_go  = fill_valid_i & ~flush_all_i;
  assign fill_we  = fill_valid_i ? victim_oh : '0;
  assign touch_en = fill_go | (lk_valid_i & any_match);
  assign touch_oh = fill_go ? victim_oh : match_vec;

  assert_outcome_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> $onehot({lk_hit_o, lk_miss_o, lk_fault_o}));

  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !(lk_hit_o | lk_miss_o | lk_fault_o) && (lk_paddr_o == '0));

  assert_flush_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_vec == '0));

  assert_fill_grows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i && !flush_all_i && !inv_page_i && !(&valid_vec)
    |=> $countones(valid_vec) == $countones($past(valid_vec)) + 1);
endmodule

// File: tb/tb_asid_tlb.sv
`timescale 1ns/1ps
module tb_asid_tlb;
  localparam int VA_W = 48, PA_W = 40, ASID_W = 8, DEPTH = 16;
  localparam int VPN_W = VA_W - 12, PPN_W = PA_W - 12;
  localparam real CLK_PERIOD = 5.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_user = 0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic [1:0] lk_acc = 2'd0;
  logic hit, miss, fault;
  logic [PA_W-1:0] paddr;
  logic fill_valid = 0, fill_global = 0;
  logic [VPN_W-1:0] fill_vpn = '0, inv_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic [1:0] fill_size = 2'd0;
  logic [3:0] fill_perm = '0;
  logic inv_page = 0, flush_all = 0;

  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_vaddr_i(lk_vaddr), .lk_asid_i(lk_asid),
    .lk_acc_i(lk_acc), .lk_user_i(lk_user),
    .lk_hit_o(hit), .lk_miss_o(miss), .lk_fault_o(fault), .lk_paddr_o(paddr),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .fill_asid_i(fill_asid), .fill_size_i(fill_size), .fill_global_i(fill_global),
    .fill_perm_i(fill_perm), .inv_page_i(inv_page), .inv_vpn_i(inv_vpn),
    .flush_all_i(flush_all)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic quiet();
    lk_valid = 0; fill_valid = 0; inv_page = 0; flush_all = 0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                      input logic [ASID_W-1:0] asid, input logic [1:0] sz,
                      input logic glob, input logic [3:0] perm);
    @(negedge clk);
    quiet();
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_asid = asid;
    fill_size = sz; fill_global = glob; fill_perm = perm;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic inval(input logic [VPN_W-1:0] vpn);
    @(negedge clk);
    quiet();
    inv_page = 1; inv_vpn = vpn;
    @(negedge clk);
    inv_page = 0;
  endtask

  // drive lookup at negedge, sample 1 ns later; request stays up across next edge
  task automatic look(input logic [VPN_W-1:0] vpn, input logic [11:0] off,
                      input logic [ASID_W-1:0] asid, input logic [1:0] acc, input logic usr);
    @(negedge clk);
    quiet();
    lk_valid = 1; lk_vaddr = {vpn, off}; lk_asid = asid; lk_acc = acc; lk_user = usr;
    #1;
  endtask

  task automatic exp_hit(input string req, input logic [VPN_W-1:0] vpn, input logic [11:0] off,
                         input logic [ASID_W-1:0] asid, input logic [1:0] acc, input logic usr,
                         input logic [PPN_W-1:0] ppn);
    look(vpn, off, asid, acc, usr);
    chk(req, {hit, miss, fault}, 3'b100);
    chk(req, paddr, {ppn, off});
  endtask

  task automatic exp_miss(input string req, input logic [VPN_W-1:0] vpn,
                          input logic [ASID_W-1:0] asid);
    look(vpn, 12'h010, asid, 2'd0, 1'b0);
    chk(req, {hit, miss, fault}, 3'b010);
    chk(req, paddr, '0);
  endtask

  task automatic exp_fault(input string req, input logic [VPN_W-1:0] vpn,
                           input logic [ASID_W-1:0] asid, input logic [1:0] acc, input logic usr);
    look(vpn, 12'h234, asid, acc, usr);
    chk(req, {hit, miss, fault}, 3'b001);
    chk(req, paddr, '0);
  endtask

  task automatic t_reset();
    chk("R6 idle", {hit, miss, fault}, 3'b000);
    chk("R6 idle paddr", paddr, '0);
    exp_miss("R1 reset", 36'h0_0001_2345, 8'd5);
    exp_miss("R1 reset", 36'h0_0000_0000, 8'd0);
  endtask

  task automatic t_basic();
    fill(36'h0_0001_2345, 28'h0ABCDE1, 8'd5, 2'd0, 1'b0, 4'hF);
    exp_hit("R2 load",  36'h0_0001_2345, 12'h5A7, 8'd5, 2'd0, 1'b1, 28'h0ABCDE1);
    exp_hit("R2 store", 36'h0_0001_2345, 12'hFFF, 8'd5, 2'd1, 1'b0, 28'h0ABCDE1);
    exp_hit("R2 fetch", 36'h0_0001_2345, 12'h000, 8'd5, 2'd2, 1'b1, 28'h0ABCDE1);
    exp_miss("R2 neighbour page", 36'h0_0001_2346, 8'd5);
    @(negedge clk); quiet();
    #1 chk("R6 idle after lookup", {hit, miss, fault, (paddr != '0)}, 4'b0000);
  endtask

  task automatic t_asid();
    exp_miss("R3 other asid", 36'h0_0001_2345, 8'd6);
    fill(36'h0_0002_0000, 28'h0000777, 8'd1, 2'd0, 1'b1, 4'hF);
    exp_hit("R3 global any asid", 36'h0_0002_0000, 12'h111, 8'd9, 2'd0, 1'b0, 28'h0000777);
    exp_hit("R3 global own asid", 36'h0_0002_0000, 12'h222, 8'd1, 2'd0, 1'b0, 28'h0000777);
  endtask

  task automatic t_sizes();
    fill(36'h0_0040_0000, 28'h0123400, 8'd5, 2'd1, 1'b0, 4'hF);
    exp_hit("R4 2M inside", 36'h0_0040_01AB, 12'h123, 8'd5, 2'd0, 1'b0, 28'h01235AB);
    exp_miss("R4 2M outside", 36'h0_0040_0200, 8'd5);
    fill(36'h0_0100_0000, 28'h0C40000, 8'd5, 2'd2, 1'b0, 4'hF);
    exp_hit("R4 1G inside", 36'h0_0102_BCDE, 12'hFFF, 8'd5, 2'd1, 1'b0, 28'h0C6BCDE);
    exp_miss("R4 1G outside", 36'h0_0104_0000, 8'd5);
  endtask

  task automatic t_perm();
    fill(36'h0_0003_0000, 28'h0000333, 8'd5, 2'd0, 1'b0, 4'b0001);
    exp_hit("R5 read ok", 36'h0_0003_0000, 12'h040, 8'd5, 2'd0, 1'b0, 28'h0000333);
    exp_hit("R5 acc3 as load", 36'h0_0003_0000, 12'h044, 8'd5, 2'd3, 1'b0, 28'h0000333);
    exp_fault("R5 store no w", 36'h0_0003_0000, 8'd5, 2'd1, 1'b0);
    exp_fault("R5 fetch no x", 36'h0_0003_0000, 8'd5, 2'd2, 1'b0);
    exp_fault("R5 user no u", 36'h0_0003_0000, 8'd5, 2'd0, 1'b1);
    fill(36'h0_0003_1000, 28'h0000444, 8'd5, 2'd0, 1'b0, 4'b1110);
    exp_fault("R5 load no r", 36'h0_0003_1000, 8'd5, 2'd0, 1'b1);
    exp_hit("R5 user store", 36'h0_0003_1000, 12'h008, 8'd5, 2'd1, 1'b1, 28'h0000444);
  endtask

  task automatic t_same_cycle();
    @(negedge clk); quiet();
    fill_valid = 1; fill_vpn = 36'h0_0005_0000; fill_ppn = 28'h0000555;
    fill_asid = 8'd5; fill_size = 2'd0; fill_global = 0; fill_perm = 4'hF;
    lk_valid = 1; lk_vaddr = {36'h0_0005_0000, 12'h0AA}; lk_asid = 8'd5; lk_acc = 2'd0; lk_user = 0;
    #1 chk("R11 fill not yet visible", {hit, miss, fault}, 3'b010);
    @(negedge clk); fill_valid = 0;
    #1 chk("R11 fill visible", {hit, miss, fault}, 3'b100);
    chk("R11 fill paddr", paddr, {28'h0000555, 12'h0AA});
    @(negedge clk); inv_page = 1; inv_vpn = 36'h0_0005_0000;
    #1 chk("R11 inv not yet applied", {hit, miss, fault}, 3'b100);
    @(negedge clk); inv_page = 0;
    #1 chk("R11 inv applied", {hit, miss, fault}, 3'b010);
  endtask

  task automatic t_inv();
    inval(36'h0_0040_0077);
    exp_miss("R9 2M removed by inner page", 36'h0_0040_01AB, 8'd5);
    exp_hit("R9 other entry kept", 36'h0_0001_2345, 12'h001, 8'd5, 2'd0, 1'b0, 28'h0ABCDE1);
    exp_hit("R9 1G kept", 36'h0_0100_0001, 12'h001, 8'd5, 2'd0, 1'b0, 28'h0C40001);
    inval(36'h0_0002_0000);
    exp_miss("R9 global removed", 36'h0_0002_0000, 8'd9);
    exp_miss("R9 global removed own asid", 36'h0_0002_0000, 8'd1);
  endtask

  task automatic t_flush();
    @(negedge clk); quiet();
    flush_all = 1; fill_valid = 1; fill_vpn = 36'h0_0006_0000; fill_ppn = 28'h0000666;
    fill_asid = 8'd5; fill_size = 2'd0; fill_global = 0; fill_perm = 4'hF;
    @(negedge clk); quiet();
    exp_miss("R10 flush beats fill", 36'h0_0006_0000, 8'd5);
    exp_miss("R10 1G flushed", 36'h0_0100_0000, 8'd5);
    exp_miss("R10 4K flushed", 36'h0_0001_2345, 8'd5);
    exp_miss("R10 perm entry flushed", 36'h0_0003_1000, 8'd5);
  endtask

  task automatic t_lru();
    for (int i = 0; i < DEPTH; i++)
      fill(36'h100 + 36'(i), 28'h900 + 28'(i), 8'd2, 2'd0, 1'b0, 4'hF);
    for (int i = 0; i < DEPTH; i++)
      exp_hit("R7 all fills kept", 36'h100 + 36'(i), 12'h0C0, 8'd2, 2'd0, 1'b0, 28'h900 + 28'(i));
    exp_hit("R8 reuse first", 36'h100, 12'h0C4, 8'd2, 2'd0, 1'b0, 28'h900);
    fill(36'h200, 28'hA00, 8'd2, 2'd0, 1'b0, 4'hF);
    exp_miss("R8 oldest evicted", 36'h101, 8'd2);
    exp_hit("R8 new fill", 36'h200, 12'h0C8, 8'd2, 2'd0, 1'b0, 28'hA00);
    exp_hit("R8 recent kept", 36'h100, 12'h0CC, 8'd2, 2'd0, 1'b0, 28'h900);
    exp_hit("R8 next kept", 36'h102, 12'h0D0, 8'd2, 2'd0, 1'b0, 28'h902);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset_pre();
    rst_n = 1;
    t_reset();
    t_basic();
    t_asid();
    t_sizes();
    t_perm();
    t_same_cycle();
    t_inv();
    t_flush();
    t_lru();
    @(negedge clk); quiet();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  task automatic t_reset_pre();
    chk("R1 outputs quiet in reset", {hit, miss, fault}, 3'b000);
  endtask
endmodule